// File: doc/BRIEF.md
# Per-Class Memory Bandwidth Delay Table

This block keeps one memory-bandwidth delay setting for every class of service and tells the memory path which delay applies to a given hardware thread. Software programs the delays through an address-mapped register port. The table occupies a window of consecutive addresses that begins at `0xD50`, and class `n` sits at `0xD50 + n`. A larger delay lets less bandwidth through for that class. Each hardware thread also has a small association register that holds its current class ID, and scheduling code rewrites it whenever a thread changes context.

A written delay is stored in quantized form, and the quantization follows the mode input that is present on the write cycle. The value is first clamped to the configured maximum delay. In linear mode it is then rounded down to a multiple of a step, where the step is 100 minus the maximum. In power-of-two mode it is rounded down to zero or to the nearest lower power of two. A configured class count limits which classes are in use. A thread whose class lies outside that range is given the default delay of zero. The credit-based throttling of the traffic itself happens in a different block.

Top module: `bw_throttle_bank`

## Requirements
- R1: After reset, every class delay reads as 0, every thread is associated with class 0, `lk_delay` is 0 and `reg_rd_data` is 0.
- R2: A write to address `0xD50 + n`, with `n` below both `NUM_REGS` and `cfg_class_count`, updates class `n` only. A write to any address outside the window `0xD50 .. 0xD50+NUM_REGS-1` changes no class, and a read of such an address returns 0.
- R3: A read request presented on one clock edge shows the stored value on `reg_rd_data` after that edge. `reg_rd_data` holds its value while `reg_rd_en` is low.
- R4: A write value that exceeds `cfg_max_delay` is clamped to `cfg_max_delay` before quantization, so no stored delay exceeds the maximum that was in force when it was written.
- R5: When `cfg_linear`=1, the stored value is the clamped value rounded down to a multiple of the step `100 - cfg_max_delay`. When `cfg_max_delay` is 100 or more, the step is 1. For example, with a maximum of 90, a write of 12 stores 10.
- R6: When `cfg_linear`=0, the stored value is 0 if the clamped value is 0. Otherwise it is the largest power of two that does not exceed the clamped value.
- R7: A write to a class index at or above `cfg_class_count` is ignored, and a read of such an index returns 0. Both also apply to a class that was programmed earlier, while the count was larger.
- R8: When `thr_set_en` is high, class `thr_set_class` is associated with thread `thr_set_id` at the next edge. `lk_delay` shows the stored delay of the class associated with `lk_thread`, with no clock delay.
- R9: When the class associated with `lk_thread` is at or above `cfg_class_count` or at or above `NUM_REGS`, `lk_delay` is 0.
- R10: Changing `cfg_linear` or `cfg_max_delay` after a write leaves the stored values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_linear | input | 1 | 1 = linear quantization, 0 = power-of-two quantization |
| cfg_max_delay | input | 8 | Maximum delay value |
| cfg_class_count | input | 7 | Number of classes in use |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Register write address |
| reg_wr_data | input | 8 | Raw delay to write |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 12 | Register read address |
| reg_rd_data | output | 8 | Stored delay, registered |
| thr_set_en | input | 1 | Association write strobe |
| thr_set_id | input | log2(NUM_THREADS) | Thread whose class is set |
| thr_set_class | input | 6 | New class ID for that thread |
| lk_thread | input | log2(NUM_THREADS) | Thread being looked up |
| lk_delay | output | 8 | Delay to enforce for that thread |

## Verification
The hardest case to reach is a class that holds a nonzero delay and then falls out of the active range. Reaching it takes an ordered sequence. The bench programs the class while the class count is large, associates a thread with it and confirms the lookup. It then lowers `cfg_class_count` and expects both the lookup and a read-back to give 0. It attempts a write while the count is low. Finally it raises the count again and expects the original value, which shows that the rejected write had no effect. The quantization rules are swept over every 8-bit write value under several maximum and mode settings, and the expected values are computed arithmetically in the bench.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

    localparam int DELAY_W  = 8;
    localparam int ADDR_W   = 12;
    localparam int CLS_ID_W = 6;
    localparam int CNT_W    = CLS_ID_W + 1;
    localparam int PCT_FULL = 100;
    localparam logic [ADDR_W-1:0] REG_BASE = 12'hD50;

    typedef logic [DELAY_W-1:0]  delay_t;
    typedef logic [CLS_ID_W-1:0] cls_id_t;
    typedef logic [CNT_W-1:0]    cls_cnt_t;

    typedef enum logic {
        QM_POW2   = 1'b0,
        QM_LINEAR = 1'b1
    } qmode_e;

    typedef struct packed {
        logic    hit;
        cls_id_t idx;
    } reg_sel_t;

    function automatic delay_t floor_pow2(delay_t v);
        delay_t r;
        r = '0;
        for (int i = 0; i < DELAY_W; i++) begin
            if (v[i]) r = delay_t'(delay_t'(1) << i);
        end
        return r;
    endfunction

    function automatic delay_t lin_step(delay_t mx);
        if (mx >= delay_t'(PCT_FULL)) return delay_t'(1);
        return delay_t'(PCT_FULL) - mx;
    endfunction

    function automatic reg_sel_t decode_addr(logic [ADDR_W-1:0] a, int unsigned n_regs);
        reg_sel_t s;
        logic [ADDR_W-1:0] off;
        off   = a - REG_BASE;
        s.hit = (a >= REG_BASE) && (off < ADDR_W'(n_regs));
        s.idx = cls_id_t'(off);
        return s;
    endfunction

endpackage

// File: rtl/bwt_quant.sv
module bwt_quant
    import bwt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  delay_t din,
    input  delay_t max_delay,
    input  qmode_e mode,
    output delay_t dout
);
    delay_t clamped;
    delay_t step;
    delay_t lin_val;
    delay_t p2_val;

    always_comb begin
        clamped = (din > max_delay) ? max_delay : din;
        step    = lin_step(max_delay);
        lin_val = clamped - (clamped % step);
        p2_val  = floor_pow2(clamped);
        dout    = (mode == QM_LINEAR) ? lin_val : p2_val;
    end

    AST_QUANT_NOT_ABOVE_MAX: assert property (@(posedge clk) disable iff (rst)
        dout <= max_delay); // R4
    AST_LIN_ON_GRID: assert property (@(posedge clk) disable iff (rst)
        (mode == QM_LINEAR) |-> ((dout % lin_step(max_delay)) == '0)); // R5
    AST_POW2_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
        (mode == QM_POW2) |-> ($countones(dout) <= 1)); // R6
    AST_QUANT_NOT_ABOVE_INPUT: assert property (@(posedge clk) disable iff (rst)
        dout <= din); // R5

endmodule

// File: rtl/bwt_class_regs.sv
module bwt_class_regs
    import bwt_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  cls_cnt_t class_count,
    input  logic     wr_en,
    input  reg_sel_t wr_sel,
    input  delay_t   wr_data,
    input  logic     rd_en,
    input  reg_sel_t rd_sel,
    output delay_t   rd_data,
    input  cls_id_t  lk_idx,
    output delay_t   lk_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    cls_cnt_t lim;
    logic     rd_ok;
    logic     lk_ok;
    delay_t   regs_q [NUM_REGS];

    always_comb begin
        lim   = (class_count > CNT_W'(NUM_REGS)) ? CNT_W'(NUM_REGS) : class_count;
        rd_ok = rd_sel.hit && ({1'b0, rd_sel.idx} < lim);
        lk_ok = ({1'b0, lk_idx} < lim);
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cls
        logic take;
        assign take = wr_en && wr_sel.hit && (wr_sel.idx == cls_id_t'(g))
                      && (CNT_W'(g) < lim);

        always_ff @(posedge clk) begin
            if (rst)       regs_q[g] <= '0;
            else if (take) regs_q[g] <= wr_data;
        end

        AST_UNTOUCHED_CLASS_STABLE: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_sel.hit && wr_sel.idx == cls_id_t'(g)) |=> $stable(regs_q[g])); // R2
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_ok ? regs_q[rd_sel.idx[IDX_W-1:0]] : '0;
    end

    assign lk_data = lk_ok ? regs_q[lk_idx[IDX_W-1:0]] : '0;

    AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_ok) |=> (rd_data == '0)); // R7
    AST_RD_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R3
    AST_RESET_CLEARS_RD: assert property (@(posedge clk)
        rst |=> (rd_data == '0)); // R1

endmodule

// File: rtl/bwt_assoc.sv
module bwt_assoc
    import bwt_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    localparam int THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [THR_W-1:0] set_thr,
    input  cls_id_t          set_cls,
    input  logic [THR_W-1:0] q_thr,
    output cls_id_t          q_cls
);
    cls_id_t cls_q [NUM_THREADS];

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst)
                cls_q[t] <= '0;
            else if (set_en && set_thr == THR_W'(t))
                cls_q[t] <= set_cls;
        end
    end

    assign q_cls = cls_q[q_thr];

    AST_ASSOC_TAKES_CLASS: assert property (@(posedge clk) disable iff (rst)
        set_en |=> (cls_q[$past(set_thr)] == $past(set_cls))); // R8

endmodule

// File: rtl/bw_throttle_bank.sv
module bw_throttle_bank
    import bwt_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int NUM_THREADS = 4,
    localparam int THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_linear,
    input  logic [7:0]        cfg_max_delay,
    input  logic [6:0]        cfg_class_count,
    input  logic              reg_wr_en,
    input  logic [11:0]       reg_wr_addr,
    input  logic [7:0]        reg_wr_data,
    input  logic              reg_rd_en,
    input  logic [11:0]       reg_rd_addr,
    output logic [7:0]        reg_rd_data,
    input  logic              thr_set_en,
    input  logic [THR_W-1:0]  thr_set_id,
    input  logic [5:0]        thr_set_class,
    input  logic [THR_W-1:0]  lk_thread,
    output logic [7:0]        lk_delay
);
    reg_sel_t wr_sel;
    reg_sel_t rd_sel;
    delay_t   q_data;
    cls_id_t  lk_cls;
    qmode_e   mode;

    always_comb begin
        wr_sel = decode_addr(reg_wr_addr, NUM_REGS);
        rd_sel = decode_addr(reg_rd_addr, NUM_REGS);
        mode   = cfg_linear ? QM_LINEAR : QM_POW2;
    end

    bwt_quant i_quant (
        .clk       (clk),
        .rst       (rst),
        .din       (reg_wr_data),
        .max_delay (cfg_max_delay),
        .mode      (mode),
        .dout      (q_data)
    );

    bwt_assoc #(.NUM_THREADS(NUM_THREADS)) i_assoc (
        .clk     (clk),
        .rst     (rst),
        .set_en  (thr_set_en),
        .set_thr (thr_set_id),
        .set_cls (thr_set_class),
        .q_thr   (lk_thread),
        .q_cls   (lk_cls)
    );

    bwt_class_regs #(.NUM_REGS(NUM_REGS)) i_regs (
        .clk         (clk),
        .rst         (rst),
        .class_count (cfg_class_count),
        .wr_en       (reg_wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (q_data),
        .rd_en       (reg_rd_en),
        .rd_sel      (rd_sel),
        .rd_data     (reg_rd_data),
        .lk_idx      (lk_cls),
        .lk_data     (lk_delay)
    );

    AST_UNMAPPED_CLASS_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (({1'b0, lk_cls} >= cfg_class_count) || ({1'b0, lk_cls} >= CNT_W'(NUM_REGS)))
        |-> (lk_delay == '0)); // R9
    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && !wr_sel.hit) |=> $stable(lk_delay) || $past(thr_set_en)
        || $past(lk_thread) != lk_thread || $past(cfg_class_count) != cfg_class_count); // R2

endmodule

// File: tb/test_bw_throttle_bank.sv
`timescale 1ns/1ps
module test_bw_throttle_bank;

    localparam int NR   = 8;
    localparam int NT   = 4;
    localparam int BASE = 'hD50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_linear = 1'b1;
    logic [7:0]  cfg_max_delay = 8'd90;
    logic [6:0]  cfg_class_count = 7'd8;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_wr_addr = '0;
    logic [7:0]  reg_wr_data = '0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_rd_addr = '0;
    logic [7:0]  reg_rd_data;
    logic        thr_set_en = 1'b0;
    logic [1:0]  thr_set_id = '0;
    logic [5:0]  thr_set_class = '0;
    logic [1:0]  lk_thread = '0;
    logic [7:0]  lk_delay;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    bw_throttle_bank #(.NUM_REGS(NR), .NUM_THREADS(NT)) i_bw_throttle_bank (
        .clk(clk), .rst(rst), .cfg_linear(cfg_linear), .cfg_max_delay(cfg_max_delay),
        .cfg_class_count(cfg_class_count), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data), .thr_set_en(thr_set_en), .thr_set_id(thr_set_id),
        .thr_set_class(thr_set_class), .lk_thread(lk_thread), .lk_delay(lk_delay)
    );

    function automatic int exp_q(int d, int mx, bit lin);
        int v;
        int p;
        v = (d > mx) ? mx : d;
        if (lin) begin
            int step;
            step = (mx >= 100) ? 1 : 100 - mx;
            return v - (v % step);
        end
        p = 0;
        for (int b = 0; b < 8; b++) if ((1 << b) <= v) p = 1 << b;
        return p;
    endfunction

    task automatic chk(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic do_write(int addr, int data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = 12'(addr); reg_wr_data = 8'(data);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic do_read(int addr, output int val);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_rd_addr = 12'(addr);
        @(negedge clk);
        reg_rd_en = 1'b0;
        val = int'(reg_rd_data);
    endtask

    task automatic do_assoc(int thr, int cls);
        @(negedge clk);
        thr_set_en = 1'b1; thr_set_id = 2'(thr); thr_set_class = 6'(cls);
        @(negedge clk);
        thr_set_en = 1'b0;
    endtask

    task automatic look(int thr, output int val);
        lk_thread = 2'(thr);
        #1;
        val = int'(lk_delay);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: got %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int v;
        int mx_set [7] = '{90, 75, 100, 200, 90, 255, 5};
        bit lin_set [7] = '{1, 1, 1, 1, 0, 0, 0};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        chk("R1 rd_data after reset", int'(reg_rd_data), 0);
        for (int c = 0; c < NR; c++) begin
            do_read(BASE + c, v);
            chk("R1 class reset value", v, 0);
        end
        for (int t = 0; t < NT; t++) begin
            look(t, v);
            chk("R1 lookup after reset", v, 0);
        end

        // R4 R5 R6 R3: full sweep of write values per configuration
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            cfg_linear = lin_set[k];
            cfg_max_delay = 8'(mx_set[k]);
            for (int d = 0; d < 256; d++) begin
                do_write(BASE + (d % NR), d);
                do_read(BASE + (d % NR), v);
                chk(lin_set[k] ? "R5 R4 R3 linear quantize" : "R6 R4 R3 pow2 quantize",
                    v, exp_q(d, mx_set[k], lin_set[k]));
            end
        end

        // R3: read data holds while no read is requested
        @(negedge clk); cfg_linear = 1'b1; cfg_max_delay = 8'd90;
        do_write(BASE + 1, 40);
        do_read(BASE + 1, v);
        do_write(BASE + 1, 70);
        repeat (2) @(negedge clk);
        chk("R3 rd_data held while idle", int'(reg_rd_data), 40);
        do_read(BASE + 1, v);
        chk("R3 new read value", v, 70);

        // R8: associations and lookup
        for (int c = 0; c < NR; c++) do_write(BASE + c, 10 * c);
        for (int t = 0; t < NT; t++) do_assoc(t, (2 * t + 1) % NR);
        for (int t = 0; t < NT; t++) begin
            look(t, v);
            chk("R8 lookup follows class", v, 10 * ((2 * t + 1) % NR));
        end
        do_assoc(0, 6);
        look(0, v);
        chk("R8 context switch", v, 60);

        // R2: addresses outside the window
        do_write(BASE - 1, 50);
        do_write(BASE + NR, 50);
        do_read(BASE, v);
        chk("R2 class0 untouched", v, 0);
        do_read(BASE + NR - 1, v);
        chk("R2 last class untouched", v, 70);
        do_read(BASE - 1, v);
        chk("R2 read below window", v, 0);
        do_read(BASE + NR, v);
        chk("R2 read above window", v, 0);

        // R7 R9: class count lowered under a programmed class
        @(negedge clk); cfg_class_count = 7'd5;
        look(0, v);
        chk("R9 lookup beyond count", v, 0);
        do_read(BASE + 6, v);
        chk("R7 read beyond count", v, 0);
        do_write(BASE + 6, 20);
        @(negedge clk); cfg_class_count = 7'd8;
        do_read(BASE + 6, v);
        chk("R7 write beyond count ignored", v, 60);
        look(0, v);
        chk("R9 lookup restored", v, 60);
        do_assoc(2, 40);
        look(2, v);
        chk("R9 class beyond table", v, 0);

        // R10: configuration change leaves stored values alone
        do_write(BASE + 3, 50);
        @(negedge clk); cfg_linear = 1'b0; cfg_max_delay = 8'd8;
        do_read(BASE + 3, v);
        chk("R10 stored value after mode change", v, 50);

        finish_run();
    end

endmodule